// File: doc/BRIEF.md
# Programmable Barrel Bit Swapper

This block permutes a 64-bit data word in one clock. Its structure is that of a barrel shifter, but each stage exchanges bits instead of shifting them. Stage n, for n from 0 to 5, can exchange every bit at position i with the bit at position i XOR 2^n. In other words, it swaps the two halves of each aligned group of 2^(n+1) bits. The stages run in ascending order, from stage 0 up to stage 5. The result is captured in an output register.

There are two ways to control the stages. In simple mode, six selector bits each switch one stage on or off for the whole word. A selector of 63 reverses the word, 7 mirrors the bits inside every byte, and 56 reverses the byte order. In field mode, each stage has its own eight-bit field:
- The three stages that work within a byte (distances 1, 2 and 4) take one enable bit per byte of the word.
- The three stages that work across bytes (distances 8, 16 and 32) take one enable bit per bit position within a byte.

Two field-mode passes are enough to transpose an 8x8 bit matrix held one row per byte.

Top module: `bswp_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `result_o` becomes all zeros after that edge, whatever the data and control inputs are.
- R2: Every operation takes one cycle. The operands sampled at one rising edge appear on `result_o` right after that edge. A new operation can be issued every cycle, and the output is always a permutation of the input, so its count of ones matches the input's.
- R3: In simple mode (`mode_i` = 0), output bit i equals input bit i XOR `ctrl_i[5:0]`. Selector 63 reverses the whole word, 7 reverses the bits within each byte, and 56 reverses the byte order.
- R4: In simple mode, `ctrl_i[63:6]` has no effect on the result.
- R5: In field mode (`mode_i` = 1), stage n for n in 0..2 swaps bits at distance 2^n inside byte b only when `ctrl_i[8n+b]` is 1.
- R6: In field mode, stage n for n in 3..5 swaps bits at distance 2^n only at byte positions p (bit index mod 8) where `ctrl_i[8n+p]` is 1.
- R7: In field mode, `ctrl_i[63:48]` has no effect on the result.
- R8: Stages run in ascending order. In field mode with `ctrl_i` = 0x0100_0001, input 0x1 gives 0x2 and input 0x2 gives 0x100.
- R9: Two field-mode passes transpose an 8x8 matrix stored as bit 8*row+col. The first pass uses control 0x0000_F0CC_AAF0_CCAA, and the second pass, applied to the first result, uses 0x0000_0000_00F0_CCAA.
- R10: A control word with no stage enabled in the current mode returns the input unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 1 | 0 = simple selector, 1 = per-field control |
| data_i | input | 64 | Word to permute |
| ctrl_i | input | 64 | Stage enables, laid out by mode |
| result_o | output | 64 | Registered permuted word |

## Verification
The bench targets the corners where a wrong design shows itself. A decoder that swapped the byte and lane indexing for the intra-byte or cross-byte stages would still pass the uniform selectors, so single-bit field controls confirm R5 and R6 exactly. Stage order is checked with a control that gives different answers when run forwards or backwards. A design that ran the stages in the wrong order would send the bit to position 0x100 instead of 0x2. The spare control bits are set to ones in both modes, and a decoder that read them would change the output word. The two-pass transpose exercises every field together, and any error in the layout would break the matrix identity.

// File: rtl/bswp_pkg.sv
// Shared definitions for the barrel bit swapper.
// Assumes the default word is 64 bits made of 8-bit lanes.
package bswp_pkg;
    localparam int unsigned WORD_W = 64;
    localparam int unsigned LANE_W = 8;

    typedef enum logic {
        MODE_SIMPLE = 1'b0,
        MODE_FIELD  = 1'b1
    } swap_mode_e;
endpackage

// File: rtl/bswp_enable_decode.sv
// Turns the mode and the control word into one enable bit per stage per
// data bit. Assumes DATA_W = LANE_W * LANE_W, so that each stage field is
// LANE_W bits wide and can cover either every byte or every lane position.
module bswp_enable_decode
    import bswp_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned LANE_W = bswp_pkg::LANE_W
) (
    input  logic                                    mode_i,
    input  logic [DATA_W-1:0]                       ctrl_i,
    output logic [$clog2(DATA_W)-1:0][DATA_W-1:0]   en_o
);
    localparam int unsigned STAGES    = $clog2(DATA_W);
    localparam int unsigned INTRA     = $clog2(LANE_W);
    localparam int unsigned CTRL_USED = STAGES * LANE_W;

    logic field_mode;
    // Mode select, shared by every enable below
    assign field_mode = (swap_mode_e'(mode_i) == MODE_FIELD);

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            localparam int unsigned GRP = i / LANE_W;
            localparam int unsigned POS = i % LANE_W;
            if (s < INTRA) begin : g_byte_ctl
                // Intra-byte stage: one field bit per byte
                assign en_o[s][i] = field_mode ? ctrl_i[s*LANE_W + GRP] : ctrl_i[s];
            end else begin : g_lane_ctl
                // Cross-byte stage: one field bit per lane position
                assign en_o[s][i] = field_mode ? ctrl_i[s*LANE_W + POS] : ctrl_i[s];
            end
        end
    end

    if (CTRL_USED < DATA_W) begin : g_spare
        logic unused_ctrl_bits;
        // Spare control bits, kept out of every enable
        assign unused_ctrl_bits = ^ctrl_i[DATA_W-1:CTRL_USED];
    end
endmodule

// File: rtl/bswp_stage.sv
// One swap stage. Each bit i takes bit i^DIST when its enable is set.
// Assumes partners carry equal enables, so the stage is a true exchange.
module bswp_stage #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned DIST   = 1
) (
    input  logic [DATA_W-1:0] d_i,
    input  logic [DATA_W-1:0] en_i,
    output logic [DATA_W-1:0] d_o
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam int unsigned PART = i ^ DIST;
        // Two-way select between own bit and partner bit
        assign d_o[i] = en_i[i] ? d_i[PART] : d_i[i];

        // Enable from the decoder must match across the swap pair
        always_comb begin
            // R6
            pair_en_chk: assert (en_i[i] == en_i[PART]);
        end
    end
endmodule

// File: rtl/bswp_unit.sv
// Top of the barrel bit swapper: enable decoder, a chain of swap stages
// in ascending distance order, and one output register.
// Assumes synchronous active-low reset and DATA_W = LANE_W * LANE_W.
module bswp_unit
    import bswp_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned LANE_W = bswp_pkg::LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] ctrl_i,
    output logic [DATA_W-1:0] result_o
);
    localparam int unsigned STAGES    = $clog2(DATA_W);
    localparam int unsigned CTRL_USED = STAGES * LANE_W;

    logic [STAGES-1:0][DATA_W-1:0] stage_en;
    logic [STAGES:0][DATA_W-1:0]   chain;

    bswp_enable_decode #(.DATA_W(DATA_W), .LANE_W(LANE_W)) dec_i (
        .mode_i (mode_i),
        .ctrl_i (ctrl_i),
        .en_o   (stage_en)
    );

    // Chain input is the raw data word
    assign chain[0] = data_i;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        bswp_stage #(.DATA_W(DATA_W), .DIST(1 << s)) stage_i (
            .d_i  (chain[s]),
            .en_i (stage_en[s]),
            .d_o  (chain[s+1])
        );
    end

    // Output register, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) result_o <= '0;
        else        result_o <= chain[STAGES];
    end

    logic [DATA_W-1:0] data_rev;
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        // Mirror of the input, used only by the checks below
        assign data_rev[i] = data_i[DATA_W-1-i];
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (result_o == '0));

    // R2
    perm_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(result_o) == $countones($past(data_i))));

    // R3
    full_reverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && (ctrl_i[STAGES-1:0] == {STAGES{1'b1}})) |=> (result_o == $past(data_rev)));

    // R10
    simple_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && (ctrl_i[STAGES-1:0] == '0)) |=> (result_o == $past(data_i)));

    // R10
    field_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && (ctrl_i[CTRL_USED-1:0] == '0)) |=> (result_o == $past(data_i)));
endmodule

// File: tb/bswp_unit_tb_top.sv
module bswp_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_i = 1'b0;
    logic [63:0] data_i = '0;
    logic [63:0] ctrl_i = '0;
    logic [63:0] result_o;

    int checks = 0;
    int failures = 0;

    bswp_unit dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .data_i(data_i), .ctrl_i(ctrl_i), .result_o(result_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Forward model: follow each source bit through the stages in order
    function automatic logic [63:0] model(input logic m, input logic [63:0] d, input logic [63:0] c);
        logic [63:0] r = '0;
        for (int q = 0; q < 64; q++) begin
            int pos = q;
            for (int s = 0; s < 6; s++) begin
                logic en;
                if (!m)        en = c[s];
                else if (s < 3) en = c[8*s + pos/8];
                else           en = c[8*s + pos%8];
                if (en) pos = pos ^ (1 << s);
            end
            r[pos] = d[q];
        end
        return r;
    endfunction

    function automatic logic [63:0] rev_all(input logic [63:0] d);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[i] = d[63-i];
        return r;
    endfunction

    function automatic logic [63:0] rev_in_bytes(input logic [63:0] d);
        logic [63:0] r;
        for (int b = 0; b < 8; b++)
            for (int k = 0; k < 8; k++) r[8*b+k] = d[8*b+7-k];
        return r;
    endfunction

    function automatic logic [63:0] rev_bytes(input logic [63:0] d);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = d[8*(7-b) +: 8];
        return r;
    endfunction

    function automatic logic [63:0] transpose(input logic [63:0] d);
        logic [63:0] r;
        for (int row = 0; row < 8; row++)
            for (int col = 0; col < 8; col++) r[8*col+row] = d[8*row+col];
        return r;
    endfunction

    // One operation: drive at a falling edge, read at the next falling edge
    task automatic run_op(input logic m, input logic [63:0] d, input logic [63:0] c,
                          output logic [63:0] res);
        @(negedge clk);
        mode_i = m; data_i = d; ctrl_i = c;
        @(negedge clk);
        res = result_o;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; mode_i = 1'b0; data_i = 64'hDEAD_BEEF_0123_4567; ctrl_i = 64'h3F;
        repeat (3) @(negedge clk);
        check("R1 reset clears output", result_o, 64'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_simple_named();
        logic [63:0] r;
        logic [63:0] d = 64'h0123_4567_89AB_CDEF;
        run_op(1'b0, d, 64'd63, r); check("R3 selector 63 full reverse", r, rev_all(d));
        run_op(1'b0, d, 64'd7,  r); check("R3 selector 7 bit mirror per byte", r, rev_in_bytes(d));
        run_op(1'b0, d, 64'd56, r); check("R3 selector 56 byte order", r, rev_bytes(d));
        run_op(1'b0, 64'h1, 64'd5, r); check("R3 selector 5 moves bit0 to bit5", r, 64'h20);
    endtask

    task automatic t_simple_ignore();
        logic [63:0] r;
        logic [63:0] d = 64'hF00F_1234_0000_8001;
        run_op(1'b0, d, 64'hFFFF_FFFF_FFFF_FFC0 | 64'd9, r);
        check("R4 simple mode ignores high control", r, model(1'b0, d, 64'd9));
        run_op(1'b0, d, 64'hFFFF_FFFF_FFFF_FFC0, r);
        check("R4 high control only is identity", r, d);
    endtask

    task automatic t_identity();
        logic [63:0] r;
        run_op(1'b0, 64'hA5A5_0F0F_3C3C_9999, 64'h0, r);
        check("R10 simple zero selector", r, 64'hA5A5_0F0F_3C3C_9999);
        run_op(1'b1, 64'h1357_9BDF_2468_ACE0, 64'h0, r);
        check("R10 field zero control", r, 64'h1357_9BDF_2468_ACE0);
    endtask

    task automatic t_field_intra();
        logic [63:0] r;
        run_op(1'b1, 64'h1, 64'h1, r);
        check("R5 stage0 byte0 swaps bits 0 and 1", r, 64'h2);
        run_op(1'b1, 64'h100, 64'h1, r);
        check("R5 stage0 byte0 leaves byte1", r, 64'h100);
        run_op(1'b1, 64'h0000_0001_0000_0000, 64'h0000_0000_0010_0000, r);
        check("R5 stage2 byte4 moves bit32 to bit36", r, 64'h0000_0010_0000_0000);
    endtask

    task automatic t_field_inter();
        logic [63:0] r;
        run_op(1'b1, 64'h1, 64'h0100_0000, r);
        check("R6 stage3 lane0 swaps bit0 with bit8", r, 64'h100);
        run_op(1'b1, 64'h2, 64'h0100_0000, r);
        check("R6 stage3 lane0 leaves lane1", r, 64'h2);
        run_op(1'b1, 64'h80, 64'h0000_8000_0000_0000, r);
        check("R6 stage5 lane7 moves bit7 to bit39", r, 64'h0000_0080_0000_0000);
    endtask

    task automatic t_field_ignore();
        logic [63:0] r;
        logic [63:0] d = 64'h0F1E_2D3C_4B5A_6978;
        run_op(1'b1, d, 64'hFFFF_0000_0000_0000, r);
        check("R7 field mode ignores top 16 control bits", r, d);
        run_op(1'b1, d, 64'hABCD_00F0_0F33_5501, r);
        check("R7 field mode with spare bits set", r, model(1'b1, d, 64'h0000_00F0_0F33_5501));
    endtask

    task automatic t_order();
        logic [63:0] r;
        run_op(1'b1, 64'h1, 64'h0100_0001, r); check("R8 ascending order bit0", r, 64'h2);
        run_op(1'b1, 64'h2, 64'h0100_0001, r); check("R8 ascending order bit1", r, 64'h100);
    endtask

    task automatic t_transpose();
        logic [63:0] r1, r2;
        logic [63:0] m = 64'h8142_2418_0F00_F0A5;
        run_op(1'b1, m, 64'h0000_F0CC_AAF0_CCAA, r1);
        run_op(1'b1, r1, 64'h0000_0000_00F0_CCAA, r2);
        check("R9 two-pass transpose", r2, transpose(m));
    endtask

    task automatic t_stream();
        logic [63:0] exp_q = '0;
        for (int k = 0; k < 21; k++) begin
            @(negedge clk);
            if (k > 0) check("R2 back-to-back one cycle latency", result_o, exp_q);
            if (k < 20) begin
                logic [63:0] d = {$urandom, $urandom};
                logic [63:0] c = {$urandom, $urandom};
                logic m = k[0];
                mode_i = m; data_i = d; ctrl_i = c;
                exp_q = model(m, d, c);
            end
        end
    endtask

    task automatic t_random();
        logic [63:0] r;
        for (int k = 0; k < 40; k++) begin
            logic [63:0] d = {$urandom, $urandom};
            logic [63:0] c = {$urandom, $urandom};
            run_op(1'b1, d, c, r);
            check("R5 R6 field mode random", r, model(1'b1, d, c));
            run_op(1'b0, d, c, r);
            check("R3 simple mode random", r, model(1'b0, d, c));
        end
    endtask

    initial begin
        t_reset();
        t_simple_named();
        t_simple_ignore();
        t_identity();
        t_field_intra();
        t_field_inter();
        t_field_ignore();
        t_order();
        t_transpose();
        t_stream();
        t_random();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        failures++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule